// File: doc/BRIEF.md
# Packet CRC Generator and Checker

This block computes a CRC over the bytes of a radio packet: the address, the packet control field and the payload. It serves both directions. A byte stream enters with a valid strobe, a start-of-packet strobe on the first byte and an end strobe on the last byte. Every accepted byte leaves on the output stream one cycle later.

In transmit direction the block appends the computed CRC bytes after the last data byte. In receive direction the input stream already carries the received CRC bytes at its end. The block then reports whether the packet is accepted.

Three modes are available: CRC off, a one-byte CRC and a two-byte CRC. Both CRC widths start from an all-ones register. Mode and direction are captured on each start-of-packet strobe. Preamble handling and address parsing are done elsewhere.

Top module: `pkt_crc_unit`

## Requirements
- R1: The mode is taken from `cfg_crc_on` and `cfg_crc_short` in the cycle `in_sop` is accepted. `cfg_crc_on`=0 selects no CRC, whatever `cfg_crc_short` is. `cfg_crc_on`=1 with `cfg_crc_short`=1 selects the one-byte CRC. `cfg_crc_on`=1 with `cfg_crc_short`=0 selects the two-byte CRC.
- R2: The one-byte CRC uses polynomial x^8+x^2+x+1 (0x07) and starts at 0xFF. Each byte is processed most significant bit first, with no reflection and no final XOR, over every byte from the `in_sop` byte to the `in_eod` byte inclusive.
- R3: The two-byte CRC uses polynomial x^16+x^12+x^5+1 (0x1021) and starts at 0xFFFF, with the same bit order and no final XOR. For the ASCII bytes "123456789" it yields 0x29B1.
- R4: A byte accepted with `in_sop`=1 restarts the CRC from the initial value, even when the previous packet had no end strobe.
- R5: Every byte accepted while `busy`=0 appears on `out_data` with `out_valid`=1 in the next cycle, unchanged and in order.
- R6: In transmit direction (`cfg_tx`=1), once the end byte has been passed through, the CRC bytes follow on consecutive cycles. The two-byte CRC sends its high byte first, then its low byte; the one-byte CRC sends a single byte. `out_last` marks the final appended byte, and `busy` is high from the cycle after the end byte until the final appended byte has been issued.
- R7: In transmit direction with CRC off, no byte is appended, `out_last` marks the end byte itself, and `busy` stays low.
- R8: In receive direction (`cfg_tx`=0), `in_eod` marks the last received CRC byte. `res_valid` pulses together with `out_last` on that byte. `res_ok` is 1 exactly when the trailing CRC bytes (high byte first) equal the CRC of all preceding bytes of the packet.
- R9: In receive direction with CRC off, every packet is reported with `res_ok`=1.
- R10: Changes of `cfg_tx`, `cfg_crc_on` or `cfg_crc_short` after the start byte have no effect on that packet.
- R11: During and right after reset, `out_valid`, `out_last`, `res_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tx | input | 1 | 1 = append CRC (transmit), 0 = check CRC (receive) |
| cfg_crc_on | input | 1 | CRC enable |
| cfg_crc_short | input | 1 | With CRC enabled: 1 = one-byte CRC, 0 = two-byte CRC |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | First byte of a packet |
| in_eod | input | 1 | Last byte of a packet |
| in_data | input | 8 | Input byte |
| busy | output | 1 | CRC bytes are being appended; input must stay idle |
| out_valid | output | 1 | Output byte strobe |
| out_last | output | 1 | Final output byte of a packet |
| out_data | output | 8 | Output byte |
| res_valid | output | 1 | Receive verdict strobe |
| res_ok | output | 1 | Receive verdict: 1 = packet accepted |

## Verification
The checker assumes that the source never offers a byte while `busy` is high. It also assumes that every byte with `in_sop` is a fresh start, so a pending verdict refers to the mode captured at that start. The bench drives each packet and then leaves the input idle for several cycles, so the append phase always completes before the next start. The configuration lines are changed only in the scrambled runs, and only after the start byte.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int BYTE_W    = 8;
    localparam int CRC_MAX_W = 16;

    typedef enum logic [1:0] {
        CRC_OFF = 2'd0,
        CRC_8   = 2'd1,
        CRC_16  = 2'd2
    } crc_mode_e;

    typedef struct packed {
        crc_mode_e              mode;
        logic                   tx;
        logic [CRC_MAX_W-1:0]   crc;
        logic [1:0]             pend;
        logic [BYTE_W-1:0]      odata;
        logic                   ovalid;
        logic                   olast;
        logic                   rvalid;
        logic                   rok;
    } crc_state_t;

endpackage

// File: rtl/crc_cfg_decode.sv
module crc_cfg_decode
    import crc_pkg::*;
(
    input  logic      crc_on,
    input  logic      crc_short,
    output crc_mode_e mode
);
    always_comb begin
        if (!crc_on) begin
            mode = CRC_OFF;
        end else if (crc_short) begin
            mode = CRC_8;
        end else begin
            mode = CRC_16;
        end
    end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
    parameter int           W    = 8,
    parameter int           BW   = 8,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic [W-1:0]  crc_in,
    input  logic [BW-1:0] byte_in,
    output logic [W-1:0]  crc_out
);
    logic [W-1:0] acc;
    logic         fb;

    // MSB first, one shift per input bit, no reflection
    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = BW - 1; i >= 0; i--) begin
            fb  = acc[W-1] ^ byte_in[i];
            acc = {acc[W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/pkt_crc_unit.sv
module pkt_crc_unit
    import crc_pkg::*;
#(
    parameter logic [7:0]  CRC8_POLY  = 8'h07,
    parameter logic [7:0]  CRC8_INIT  = 8'hFF,
    parameter logic [15:0] CRC16_POLY = 16'h1021,
    parameter logic [15:0] CRC16_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx,
    input  logic              cfg_crc_on,
    input  logic              cfg_crc_short,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eod,
    input  logic [BYTE_W-1:0] in_data,
    output logic              busy,
    output logic              out_valid,
    output logic              out_last,
    output logic [BYTE_W-1:0] out_data,
    output logic              res_valid,
    output logic              res_ok
);
    localparam int SHORT_W = 8;
    localparam int LONG_W  = CRC_MAX_W;
    localparam int HI_LSB  = LONG_W - BYTE_W;

    crc_state_t q, d;

    crc_mode_e          cfg_mode;
    crc_mode_e          mode_now;
    logic               tx_now;
    logic [SHORT_W-1:0] base8,  nxt8;
    logic [LONG_W-1:0]  base16, nxt16;
    crc_mode_e          mode_q_w;
    logic               tx_q_w;

    crc_cfg_decode u_dec (
        .crc_on    (cfg_crc_on),
        .crc_short (cfg_crc_short),
        .mode      (cfg_mode)
    );

    assign mode_now = in_sop ? cfg_mode : q.mode;
    assign tx_now   = in_sop ? cfg_tx   : q.tx;
    assign base8    = in_sop ? CRC8_INIT  : q.crc[SHORT_W-1:0];
    assign base16   = in_sop ? CRC16_INIT : q.crc;

    crc_byte_step #(.W(SHORT_W), .BW(BYTE_W), .POLY(CRC8_POLY)) u_step8 (
        .crc_in  (base8),
        .byte_in (in_data),
        .crc_out (nxt8)
    );

    crc_byte_step #(.W(LONG_W), .BW(BYTE_W), .POLY(CRC16_POLY)) u_step16 (
        .crc_in  (base16),
        .byte_in (in_data),
        .crc_out (nxt16)
    );

    always_comb begin
        d        = q;
        d.ovalid = 1'b0;
        d.olast  = 1'b0;
        d.rvalid = 1'b0;
        d.rok    = 1'b0;
        if (q.pend != 2'd0) begin
            // append phase: high byte when two remain, low byte last
            d.ovalid = 1'b1;
            d.odata  = (q.pend == 2'd2) ? q.crc[LONG_W-1:HI_LSB] : q.crc[BYTE_W-1:0];
            d.olast  = (q.pend == 2'd1);
            d.pend   = q.pend - 2'd1;
        end else if (in_valid) begin
            d.mode   = mode_now;
            d.tx     = tx_now;
            d.crc    = (mode_now == CRC_8) ? {{(LONG_W-SHORT_W){1'b0}}, nxt8} : nxt16;
            d.ovalid = 1'b1;
            d.odata  = in_data;
            if (in_eod) begin
                if (tx_now) begin
                    unique case (mode_now)
                        CRC_8:   d.pend  = 2'd1;
                        CRC_16:  d.pend  = 2'd2;
                        default: d.olast = 1'b1;
                    endcase
                end else begin
                    d.olast  = 1'b1;
                    d.rvalid = 1'b1;
                    unique case (mode_now)
                        CRC_8:   d.rok = (nxt8 == '0);
                        CRC_16:  d.rok = (nxt16 == '0);
                        default: d.rok = 1'b1;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: CRC_OFF, tx: 1'b0, crc: '0, pend: 2'd0, odata: '0,
                   ovalid: 1'b0, olast: 1'b0, rvalid: 1'b0, rok: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.pend != 2'd0);
    assign out_valid = q.ovalid;
    assign out_last  = q.olast;
    assign out_data  = q.odata;
    assign res_valid = q.rvalid;
    assign res_ok    = q.rok;
    assign mode_q_w  = q.mode;
    assign tx_q_w    = q.tx;

endmodule

// File: rtl/pkt_crc_unit_chk.sv
module pkt_crc_unit_chk
    import crc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      in_valid,
    input logic      busy,
    input logic      out_valid,
    input logic      out_last,
    input logic      res_valid,
    input logic      res_ok,
    input crc_mode_e mode_q,
    input logic      tx_q
);
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R6

    AST_BUSY_FEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> out_valid); // R6

    AST_SOURCE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_valid); // R6

    AST_BYTE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> out_valid); // R5

    AST_VERDICT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (out_valid && out_last)); // R8

    AST_VERDICT_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !tx_q); // R8

    AST_OFF_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mode_q == CRC_OFF) |-> res_ok); // R9
endmodule

bind pkt_crc_unit pkt_crc_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_last  (out_last),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .mode_q    (mode_q_w),
    .tx_q      (tx_q_w)
);

// File: tb/sim_pkt_crc_unit.sv
`timescale 1ns/1ps
module sim_pkt_crc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_tx = 1'b0, cfg_crc_on = 1'b0, cfg_crc_short = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eod = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       busy, out_valid, out_last, res_valid, res_ok;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;

    pkt_crc_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_crc_on(cfg_crc_on),
        .cfg_crc_short(cfg_crc_short), .in_valid(in_valid), .in_sop(in_sop),
        .in_eod(in_eod), .in_data(in_data), .busy(busy), .out_valid(out_valid),
        .out_last(out_last), .out_data(out_data), .res_valid(res_valid), .res_ok(res_ok)
    );

    int         n_cmp = 0, n_bad = 0;
    logic [7:0] pkt [0:39];
    logic [7:0] cap [0:47];
    int         cap_n = 0, last_idx = -1, res_seen = 0;
    logic       res_val = 1'b0, busy_after = 1'b0;
    bit         done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int w, input int n);
        logic [15:0] c, p, top;
        c   = (w == 8) ? 16'h00FF : 16'hFFFF;
        p   = (w == 8) ? 16'h0007 : 16'h1021;
        top = (w == 8) ? 16'h0080 : 16'h8000;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = ((c & top) != 0) ^ pkt[k][b];
                c  = c << 1;
                if (fb) c = c ^ p;
                if (w == 8) c = c & 16'h00FF;
            end
        end
        return c;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (cap_n < 48) cap[cap_n] = out_data;
                if (out_last) last_idx = cap_n;
                cap_n++;
            end
            if (res_valid) begin
                res_seen++;
                res_val = res_ok;
            end
        end
    end

    task automatic run_pkt(input int n, input bit tx, input bit on, input bit sh,
                           input bit scr, input bit eod_en);
        cap_n = 0; last_idx = -1; res_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                cfg_tx = tx; cfg_crc_on = on; cfg_crc_short = sh;
            end else if (scr) begin
                cfg_tx = !tx; cfg_crc_on = !on; cfg_crc_short = !sh;
            end
            in_valid = 1'b1; in_sop = (i == 0);
            in_eod = eod_en && (i == n - 1); in_data = pkt[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eod = 1'b0;
        busy_after = busy;
        repeat (5) @(negedge clk);
    endtask

    // w: 0 = off, 8 or 16
    task automatic chk_tx(input int n, input int w, input string tag);
        int          nb;
        logic [15:0] e, g;
        bit          same;
        nb   = w / 8;
        e    = (w == 0) ? 16'h0 : ref_crc(w, n);
        same = 1'b1;
        for (int i = 0; i < n; i++) if (cap[i] !== pkt[i]) same = 1'b0;
        chk(same, {tag, " R5 pass-through"}, same, 1);
        chk(cap_n == n + nb, {tag, " R6/R7 byte count"}, cap_n, n + nb);
        g = (nb == 2) ? {cap[n], cap[n+1]} : (nb == 1) ? {8'h00, cap[n]} : 16'h0;
        if (nb != 0) chk(g == e, {tag, (w == 8) ? " R2 crc8" : " R3 crc16"}, g, e);
        chk(last_idx == n + nb - 1, {tag, " R6 last marker"}, last_idx, n + nb - 1);
        chk(busy_after == (nb != 0), {tag, " R6 busy"}, busy_after, nb != 0);
    endtask

    task automatic chk_rx(input int total, input bit exp_ok, input string tag);
        chk(res_seen == 1, {tag, " R8 one verdict"}, res_seen, 1);
        chk(res_val == exp_ok, {tag, " R8 verdict"}, res_val, exp_ok);
        chk(cap_n == total && last_idx == total - 1, {tag, " R8 last"}, last_idx, total - 1);
    endtask

    // build n data bytes then append CRC of width w (high byte first)
    task automatic seal(input int n, input int w);
        logic [15:0] c;
        c = ref_crc(w, n);
        if (w == 16) begin pkt[n] = c[15:8]; pkt[n+1] = c[7:0]; end
        else pkt[n] = c[7:0];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_last && !res_valid && !busy, "R11 in reset",
            {out_valid, out_last, res_valid, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_last && !res_valid && !busy, "R11 after reset",
            {out_valid, out_last, res_valid, busy}, 0);

        // R3 known vector "123456789"
        for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + i[7:0];
        run_pkt(9, 1, 1, 0, 0, 1);
        chk({cap[9], cap[10]} == 16'h29B1, "R3 check value", {cap[9], cap[10]}, 16'h29B1);

        // R1 R2 R3 R7: one-byte packets, every value, every mode setting
        for (int v = 0; v < 256; v++) begin
            for (int m = 0; m < 4; m++) begin
                pkt[0] = v[7:0];
                run_pkt(1, 1, m[1], m[0], 0, 1);
                chk_tx(1, m[1] ? (m[0] ? 8 : 16) : 0, "R1 sweep");
            end
        end

        // multi-byte transmit, varying lengths
        for (int n = 2; n <= 32; n += 5) begin
            for (int i = 0; i < n; i++) pkt[i] = 8'(i * 37 + n);
            run_pkt(n, 1, 1, 1, 0, 1); chk_tx(n, 8, "R2 long");
            run_pkt(n, 1, 1, 0, 0, 1); chk_tx(n, 16, "R3 long");
            run_pkt(n, 1, 0, 0, 0, 1); chk_tx(n, 0, "R7 long");
            run_pkt(n, 1, 1, 0, 1, 1); chk_tx(n, 16, "R10 tx scramble");
        end

        // R4: an unfinished packet followed by a fresh start
        for (int i = 0; i < 3; i++) pkt[i] = 8'hA5 ^ i[7:0];
        run_pkt(3, 1, 1, 0, 0, 0);
        for (int i = 0; i < 6; i++) pkt[i] = 8'(i + 9);
        run_pkt(6, 1, 1, 0, 0, 1); chk_tx(6, 16, "R4 restart16");
        for (int i = 0; i < 3; i++) pkt[i] = 8'h5A ^ i[7:0];
        run_pkt(3, 1, 1, 1, 0, 0);
        for (int i = 0; i < 6; i++) pkt[i] = 8'(i + 9);
        run_pkt(6, 1, 1, 1, 0, 1); chk_tx(6, 8, "R4 restart8");

        // R8: receive, good packets and every single-bit corruption
        for (int w = 8; w <= 16; w += 8) begin
            for (int i = 0; i < 4; i++) pkt[i] = 8'(i * 51 + w);
            seal(4, w);
            run_pkt(4 + w / 8, 0, 1, w == 8, 0, 1);
            chk_rx(4 + w / 8, 1, "R8 good");
            run_pkt(4 + w / 8, 0, 1, w == 8, 1, 1);
            chk_rx(4 + w / 8, 1, "R10 rx scramble");
            for (int k = 0; k < 4 + w / 8; k++) begin
                for (int b = 0; b < 8; b++) begin
                    pkt[k][b] = ~pkt[k][b];
                    run_pkt(4 + w / 8, 0, 1, w == 8, 0, 1);
                    chk_rx(4 + w / 8, 0, "R8 flipped");
                    run_pkt(4 + w / 8, 0, 0, w == 8, 0, 1);
                    chk_rx(4 + w / 8, 1, "R9 off accepts");
                    pkt[k][b] = ~pkt[k][b];
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule